// File: doc/BRIEF.md
# SMBus Block Transfer Buffer

This block sits between a host register unit and an SMBus protocol engine and carries the data of block read and block write transactions. Software reaches it through a small byte-wide register window. The protocol engine reaches it through two byte streams, each with a valid/ready handshake: one stream toward the bus for writes and one from the bus for reads. Bit timing on the wire and packet error code arithmetic stay inside the engine. This block only stores the enable for the error code.

Two modes are selected by an auxiliary control bit. In buffered mode a 32-entry byte store is filled or drained through one block-data register whose index advances on every access. Reading the control register returns that index to zero. In byte-at-a-time mode, which is the reset default, every byte moves through a single holding register. The transfer stalls after each byte until software clears the byte-done flag by writing a one to it. The byte count lives in the count register. On an SMBus block read the first received byte is the length and is written into the count register. The last-byte variant of the command marks which read byte ends the transaction.

Top module: `smb_blkbuf`

## Requirements
- R1: After reset the status (offset 0), control (offset 2), count (offset 5) and auxiliary (offset 13) registers read 0x00 and `pec_en_o` is low, so byte-at-a-time mode is active.
- R2: Auxiliary register bits [1:0] are read/write. Bit 1 set selects buffered mode and bit 0 drives `pec_en_o`.
- R3: In buffered mode each access to the block-data register (offset 7) writes or reads the next buffer entry, starting at entry 0. Any read of the control register resets that index to 0.
- R4: A control write with bit 6 set and command field bits [4:2] equal to 5 (SMBus block) or 6 (I2C block) starts a transfer and pulses `start_o`. For a write in buffered mode, buffer entries 0..N-1 are offered in order, where N is the count, and `tx_last_o` is high on entry N-1 only.
- R5: On a buffered SMBus block read, the first received byte is stored in the count register. The following bytes fill entries 0 upward, and `rx_final_o` is high only on the byte that completes the count.
- R6: A received length of 0 or above 32 sets the failed flag (status bit 4), pulses `abort_o`, ends the transfer and stores nothing. A start whose count is outside 1..32, on a write or an I2C read, sets the failed flag without pulsing `start_o` or offering any byte.
- R7: In byte-at-a-time mode the byte-done flag (status bit 7) is set after each byte. While it stays set, `tx_valid_o` and `rx_ready_o` are held low. Writing a one to bit 7 releases the next byte.
- R8: In byte-at-a-time reads each received byte is readable at the block-data register. `rx_final_o` follows control bit 5 (the last-byte bit, command codes 0x34/0x38), and the byte taken with it ends the transfer.
- R9: Status bit 0 is high while a transfer runs. Bit 1 (done) is set when a transfer completes. Bits 7, 4 and 1 are cleared by writing ones to them.
- R10: The block never offers a byte toward the bus and accepts a byte from the bus in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Access is a write |
| reg_addr_i | input | 4 | Register offset |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, valid in the cycle of the strobe |
| xfer_read_i | input | 1 | Transfer direction from the address register (1 = read) |
| pec_en_o | output | 1 | Error-code enable to the protocol engine |
| start_o | output | 1 | One-cycle pulse when a transfer is accepted |
| abort_o | output | 1 | One-cycle pulse when an illegal length ends a read |
| tx_valid_o | output | 1 | Byte toward the bus is valid |
| tx_ready_i | input | 1 | Engine takes the byte |
| tx_data_o | output | 8 | Byte toward the bus |
| tx_last_o | output | 1 | Offered byte is the final one |
| rx_valid_i | input | 1 | Byte from the bus is valid |
| rx_ready_o | output | 1 | Block accepts the byte |
| rx_data_i | input | 8 | Byte from the bus |
| rx_final_o | output | 1 | Accepted byte is final and must not be acknowledged |

## Verification
Register read data is due in the same cycle as the strobe. Status flags, the count update and the `start_o`/`abort_o` pulses are due one clock edge after the accepting write or handshake. The first byte toward the bus is offered in the cycle after the start, or one cycle later in byte-at-a-time mode. The bench drives every input on the falling edge and samples outputs on the falling edge one edge after the event, so each result is taken a full half-period after the register that produces it has settled. Bytes expected toward the bus are queued by the driver and popped by a monitor at the falling edge of each handshake cycle. Any offer while the queue is empty counts as a failure, which covers the cases where nothing may be sent.

// File: rtl/sbb_pkg.sv
package sbb_pkg;
  localparam int unsigned BUF_BYTES = 32;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned OFS_W     = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_LEN, ST_DATA, ST_HOLD} sbb_state_e;

  localparam logic [OFS_W-1:0] OFS_STAT = 4'd0;
  localparam logic [OFS_W-1:0] OFS_CTRL = 4'd2;
  localparam logic [OFS_W-1:0] OFS_CNT  = 4'd5;
  localparam logic [OFS_W-1:0] OFS_BLK  = 4'd7;
  localparam logic [OFS_W-1:0] OFS_AUX  = 4'd13;

  localparam logic [2:0] KIND_SMB_BLK = 3'd5;
  localparam logic [2:0] KIND_I2C_BLK = 3'd6;
endpackage

// File: rtl/sbb_mem.sv
module sbb_mem #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [DW-1:0] rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_b_o
);
  logic [DW-1:0] cell_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cell_q[e] <= '0;
      else if (we_i && waddr_i == AW'(e)) cell_q[e] <= wdata_i;
    end
  end

  assign rdata_a_o = cell_q[raddr_a_i];
  assign rdata_b_o = cell_q[raddr_b_i];
endmodule

// File: rtl/sbb_ctl.sv
module sbb_ctl
  import sbb_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          smbus_i,
  input  logic          read_i,
  input  logic          buffered_i,
  input  logic          last_bit_i,
  input  logic [DW-1:0] cnt_i,
  input  logic [2:0]    clr_i,      // {byte_done, failed, done}
  input  logic          tx_ready_i,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  output logic [AW-1:0] pos_o,
  output logic          mode_o,
  output logic          tx_valid_o,
  output logic          tx_last_o,
  output logic          rx_ready_o,
  output logic          rx_final_o,
  output logic          mem_we_o,
  output logic          hold_we_o,
  output logic          len_we_o,
  output logic          start_o,
  output logic          abort_o,
  output logic          busy_o,
  output logic          byte_done_o,
  output logic          failed_o,
  output logic          done_o
);
  localparam logic [DW-1:0] DEPTH_W = DW'(DEPTH);

  sbb_state_e    state_q, state_d;
  logic [AW-1:0] pos_q, pos_d;
  logic          mode_q, dir_q, bd_q, fail_q, done_q, start_q, abort_q;
  logic          accept, set_bd, set_fail, set_done, abort_d;
  logic          tx_hs, rx_hs, last_by_cnt, len_bad, cnt_ok, fin;
  logic [DW-1:0] pos_next;

  assign pos_next    = DW'(pos_q) + DW'(1);
  assign last_by_cnt = (pos_next == cnt_i);
  assign len_bad     = (rx_data_i == '0) || (rx_data_i > DEPTH_W);
  assign cnt_ok      = (cnt_i != '0) && (cnt_i <= DEPTH_W);

  assign tx_valid_o = (state_q == ST_DATA) && !dir_q;
  assign rx_ready_o = ((state_q == ST_DATA) || (state_q == ST_LEN)) && dir_q;
  assign tx_last_o  = tx_valid_o && last_by_cnt;
  assign rx_final_o = (state_q == ST_DATA) && dir_q && (mode_q ? last_by_cnt : last_bit_i);
  assign tx_hs      = tx_valid_o && tx_ready_i;
  assign rx_hs      = rx_ready_o && rx_valid_i;
  assign fin        = dir_q ? rx_final_o : tx_last_o;

  assign mem_we_o  = rx_hs && (state_q == ST_DATA) && mode_q;
  assign hold_we_o = rx_hs && (state_q == ST_DATA) && !mode_q;
  assign len_we_o  = rx_hs && (state_q == ST_LEN) && !len_bad;

  always_comb begin
    state_d  = state_q;
    pos_d    = pos_q;
    accept   = 1'b0;
    set_bd   = 1'b0;
    set_fail = 1'b0;
    set_done = 1'b0;
    abort_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        if (read_i && smbus_i) begin
          accept  = 1'b1;
          state_d = ST_LEN;
        end else if (cnt_ok) begin
          accept  = 1'b1;
          state_d = buffered_i ? ST_DATA : ST_HOLD;
        end else begin
          set_fail = 1'b1;
        end
        pos_d = '0;
      end
      ST_LEN: if (rx_hs) begin
        if (len_bad) begin
          set_fail = 1'b1;
          abort_d  = 1'b1;
          state_d  = ST_IDLE;
        end else begin
          state_d = ST_DATA;
        end
      end
      ST_DATA: if (tx_hs || rx_hs) begin
        set_bd = !mode_q;
        if (fin) begin
          set_done = 1'b1;
          state_d  = ST_IDLE;
        end else begin
          pos_d   = pos_q + 1'b1;
          state_d = mode_q ? ST_DATA : ST_HOLD;
        end
      end
      ST_HOLD: if (!bd_q) state_d = ST_DATA;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      mode_q  <= 1'b0;
      dir_q   <= 1'b0;
      bd_q    <= 1'b0;
      fail_q  <= 1'b0;
      done_q  <= 1'b0;
      start_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      start_q <= accept;
      abort_q <= abort_d;
      if (accept) begin
        mode_q <= buffered_i;
        dir_q  <= read_i;
      end
      bd_q   <= (bd_q & ~clr_i[2]) | set_bd;
      fail_q <= (fail_q & ~clr_i[1]) | set_fail;
      done_q <= (done_q & ~clr_i[0]) | set_done;
    end
  end

  assign pos_o       = pos_q;
  assign mode_o      = mode_q;
  assign start_o     = start_q;
  assign abort_o     = abort_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign byte_done_o = bd_q;
  assign failed_o    = fail_q;
  assign done_o      = done_q;

  // R10
  tx_rx_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_valid_o && rx_ready_o));

  // R7
  byte_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q && bd_q && state_q != ST_IDLE) |-> (!tx_valid_o && !rx_ready_o));

  // R6
  bad_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LEN && rx_hs && len_bad) |=> (state_q == ST_IDLE && fail_q && abort_o));

  // R8
  final_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_hs && rx_final_o) |=> (state_q == ST_IDLE && done_q));

  // R4
  last_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_hs && tx_last_o) |=> (state_q == ST_IDLE && done_q));
endmodule

// File: rtl/smb_blkbuf.sv
module smb_blkbuf
  import sbb_pkg::*;
#(
  parameter int unsigned DEPTH = BUF_BYTES,
  localparam int unsigned DW   = BYTE_W,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_req_i,
  input  logic             reg_we_i,
  input  logic [OFS_W-1:0] reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  input  logic             xfer_read_i,
  output logic             pec_en_o,
  output logic             start_o,
  output logic             abort_o,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  output logic [DW-1:0]    tx_data_o,
  output logic             tx_last_o,
  input  logic             rx_valid_i,
  output logic             rx_ready_o,
  input  logic [DW-1:0]    rx_data_i,
  output logic             rx_final_o
);
  logic [1:0]    aux_q;
  logic [3:0]    cmd_q;
  logic [DW-1:0] cnt_q, hold_q, sw_rd, eng_rd, mem_wdata;
  logic [AW-1:0] idx_q, pos, mem_waddr;
  logic          wr, rd, ctrl_wr, start_req, blk_acc, mem_we;
  logic          mode, mem_we_e, hold_we_e, len_we_e, busy, bd, failed, done;
  logic [2:0]    new_kind, clr;

  assign wr        = reg_req_i && reg_we_i;
  assign rd        = reg_req_i && !reg_we_i;
  assign ctrl_wr   = wr && reg_addr_i == OFS_CTRL;
  assign new_kind  = reg_wdata_i[4:2];
  assign start_req = ctrl_wr && reg_wdata_i[6] &&
                     (new_kind == KIND_SMB_BLK || new_kind == KIND_I2C_BLK);
  assign blk_acc   = reg_req_i && reg_addr_i == OFS_BLK;
  assign clr       = (wr && reg_addr_i == OFS_STAT) ?
                     {reg_wdata_i[7], reg_wdata_i[4], reg_wdata_i[1]} : 3'b000;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aux_q  <= '0;
      cmd_q  <= '0;
      cnt_q  <= '0;
      hold_q <= '0;
      idx_q  <= '0;
    end else begin
      if (wr && reg_addr_i == OFS_AUX) aux_q <= reg_wdata_i[1:0];
      if (ctrl_wr) cmd_q <= reg_wdata_i[5:2];
      if (len_we_e) cnt_q <= rx_data_i;
      else if (wr && reg_addr_i == OFS_CNT) cnt_q <= reg_wdata_i;
      if (hold_we_e) hold_q <= rx_data_i;
      else if (wr && blk_acc && !aux_q[1]) hold_q <= reg_wdata_i;
      if (rd && reg_addr_i == OFS_CTRL) idx_q <= '0;
      else if (blk_acc && aux_q[1]) idx_q <= idx_q + 1'b1;
    end
  end

  assign mem_we    = mem_we_e || (wr && blk_acc && aux_q[1]);
  assign mem_waddr = mem_we_e ? pos : idx_q;
  assign mem_wdata = mem_we_e ? rx_data_i : reg_wdata_i;

  sbb_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (mem_we),
    .waddr_i   (mem_waddr),
    .wdata_i   (mem_wdata),
    .raddr_a_i (idx_q),
    .rdata_a_o (sw_rd),
    .raddr_b_i (pos),
    .rdata_b_o (eng_rd)
  );

  sbb_ctl #(.DEPTH(DEPTH), .DW(DW)) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_req),
    .smbus_i     (new_kind == KIND_SMB_BLK),
    .read_i      (xfer_read_i),
    .buffered_i  (aux_q[1]),
    .last_bit_i  (cmd_q[3]),
    .cnt_i       (cnt_q),
    .clr_i       (clr),
    .tx_ready_i  (tx_ready_i),
    .rx_valid_i  (rx_valid_i),
    .rx_data_i   (rx_data_i),
    .pos_o       (pos),
    .mode_o      (mode),
    .tx_valid_o  (tx_valid_o),
    .tx_last_o   (tx_last_o),
    .rx_ready_o  (rx_ready_o),
    .rx_final_o  (rx_final_o),
    .mem_we_o    (mem_we_e),
    .hold_we_o   (hold_we_e),
    .len_we_o    (len_we_e),
    .start_o     (start_o),
    .abort_o     (abort_o),
    .busy_o      (busy),
    .byte_done_o (bd),
    .failed_o    (failed),
    .done_o      (done)
  );

  assign tx_data_o = mode ? eng_rd : hold_q;
  assign pec_en_o  = aux_q[0];

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFS_STAT: reg_rdata_o = {bd, 2'b00, failed, 2'b00, done, busy};
      OFS_CTRL: reg_rdata_o = {2'b00, cmd_q, 2'b00};
      OFS_CNT:  reg_rdata_o = cnt_q;
      OFS_BLK:  reg_rdata_o = aux_q[1] ? sw_rd : hold_q;
      OFS_AUX:  reg_rdata_o = {6'b0, aux_q};
      default:  reg_rdata_o = '0;
    endcase
  end

  // R3
  idx_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && reg_addr_i == OFS_CTRL) |=> (idx_q == '0));

  // R2
  pec_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && reg_addr_i == OFS_AUX) |=> (pec_en_o == $past(reg_wdata_i[0])));
endmodule

// File: tb/smb_blkbuf_test.sv
module smb_blkbuf_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic       xfer_read = 1'b0;
  logic       pec_en, start_p, abort_p;
  logic       tx_valid, tx_last, rx_ready, rx_final;
  logic       tx_ready = 1'b1;
  logic       rx_valid = 1'b0;
  logic [7:0] tx_data, rx_data = '0;

  int checks = 0, fails = 0, n_start = 0, n_abort = 0;
  logic [8:0] exp_q[$];
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  smb_blkbuf uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .xfer_read_i(xfer_read), .pec_en_o(pec_en),
    .start_o(start_p), .abort_o(abort_p),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data), .tx_last_o(tx_last),
    .rx_valid_i(rx_valid), .rx_ready_o(rx_ready), .rx_data_i(rx_data), .rx_final_o(rx_final)
  );

  task automatic chk(input bit ok, input string req_tag, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req_tag, what, act, expv);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [7:0] expv,
                        input string req_tag, input string what);
    logic [7:0] v;
    reg_rd(a, v);
    chk(v == expv, req_tag, what, int'(v), int'(expv));
  endtask

  task automatic wait_stat(input logic [7:0] mask);
    logic [7:0] v;
    for (int i = 0; i < 200; i++) begin
      reg_rd(4'd0, v);
      if ((v & mask) != 0) return;
    end
  endtask

  task automatic rx_send(input logic [7:0] d, output logic fin);
    @(negedge clk); rx_valid = 1'b1; rx_data = d;
    #1;
    while (!rx_ready) begin @(negedge clk); #1; end
    fin = rx_final;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  // scoreboard monitor: byte offered at this falling edge is taken at the next rising edge
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6", "unexpected tx byte", int'(tx_data), 0);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk({tx_last, tx_data} == e, "R4", "tx byte/last", int'({tx_last, tx_data}), int'(e));
      end
    end
    if (rst_n && start_p) n_start++;
    if (rst_n && abort_p) n_abort++;
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done_flag) begin
      chk(1'b0, "R1", "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic f;
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_chk(4'd0, 8'h00, "R1", "status after reset");
    rd_chk(4'd2, 8'h00, "R1", "control after reset");
    rd_chk(4'd5, 8'h00, "R1", "count after reset");
    rd_chk(4'd13, 8'h00, "R1", "aux after reset");
    chk(pec_en == 1'b0, "R1", "pec_en after reset", int'(pec_en), 0);

    // R2 aux register
    reg_wr(4'd13, 8'h03);
    rd_chk(4'd13, 8'h03, "R2", "aux readback");
    chk(pec_en == 1'b1, "R2", "pec_en set", int'(pec_en), 1);
    reg_wr(4'd13, 8'h02);
    chk(pec_en == 1'b0, "R2", "pec_en clear", int'(pec_en), 0);

    // R3 buffered fill and readback, R4 buffered write
    reg_wr(4'd5, 8'd3);
    reg_wr(4'd7, 8'hA1); reg_wr(4'd7, 8'hB2); reg_wr(4'd7, 8'hC3);
    reg_rd(4'd2, v);
    rd_chk(4'd7, 8'hA1, "R3", "buffer entry 0");
    rd_chk(4'd7, 8'hB2, "R3", "buffer entry 1");
    rd_chk(4'd7, 8'hC3, "R3", "buffer entry 2");
    exp_q.push_back({1'b0, 8'hA1});
    exp_q.push_back({1'b0, 8'hB2});
    exp_q.push_back({1'b1, 8'hC3});
    s0 = n_start;
    xfer_read = 1'b0;
    reg_wr(4'd2, 8'h54);
    wait_stat(8'h02);
    chk(exp_q.size() == 0, "R4", "all bytes sent", exp_q.size(), 0);
    chk(n_start == s0 + 1, "R4", "start pulse count", n_start - s0, 1);
    rd_chk(4'd0, 8'h02, "R9", "done after write");
    reg_wr(4'd0, 8'h02);
    rd_chk(4'd0, 8'h00, "R9", "done cleared");

    // R5 buffered SMBus block read
    xfer_read = 1'b1;
    reg_wr(4'd2, 8'h54);
    rd_chk(4'd0, 8'h01, "R9", "busy during read");
    rx_send(8'd4, f);  chk(f == 1'b0, "R5", "length byte not final", int'(f), 0);
    rx_send(8'h11, f); chk(f == 1'b0, "R5", "byte 1 not final", int'(f), 0);
    rx_send(8'h22, f); chk(f == 1'b0, "R5", "byte 2 not final", int'(f), 0);
    rx_send(8'h33, f); chk(f == 1'b0, "R5", "byte 3 not final", int'(f), 0);
    rx_send(8'h44, f); chk(f == 1'b1, "R5", "byte 4 final", int'(f), 1);
    rd_chk(4'd5, 8'd4, "R5", "length in count");
    rd_chk(4'd2, 8'h14, "R3", "control readback resets index");
    rd_chk(4'd7, 8'h11, "R5", "read entry 0");
    rd_chk(4'd7, 8'h22, "R5", "read entry 1");
    rd_chk(4'd7, 8'h33, "R5", "read entry 2");
    rd_chk(4'd7, 8'h44, "R5", "read entry 3");
    rd_chk(4'd0, 8'h02, "R9", "done after read");
    reg_wr(4'd0, 8'h02);

    // R6 illegal lengths
    s0 = n_abort;
    reg_wr(4'd2, 8'h54);
    rx_send(8'd0, f);
    rd_chk(4'd0, 8'h10, "R6", "failed on length 0");
    chk(n_abort == s0 + 1, "R6", "abort on length 0", n_abort - s0, 1);
    rd_chk(4'd5, 8'd4, "R6", "count kept on length 0");
    reg_wr(4'd0, 8'h10);
    reg_wr(4'd2, 8'h54);
    rx_send(8'd33, f);
    rd_chk(4'd0, 8'h10, "R6", "failed on length 33");
    chk(n_abort == s0 + 2, "R6", "abort on length 33", n_abort - s0, 2);
    reg_rd(4'd2, v);
    rd_chk(4'd7, 8'h11, "R6", "nothing stored");
    reg_wr(4'd0, 8'h10);
    s0 = n_start;
    xfer_read = 1'b0;
    reg_wr(4'd5, 8'd0);
    reg_wr(4'd2, 8'h54);
    repeat (3) @(negedge clk);
    rd_chk(4'd0, 8'h10, "R6", "failed on zero count write");
    chk(n_start == s0, "R6", "no start on zero count", n_start - s0, 0);
    reg_wr(4'd0, 8'h10);

    // R7 byte-at-a-time write
    reg_wr(4'd13, 8'h00);
    reg_wr(4'd5, 8'd2);
    reg_wr(4'd7, 8'h5A);
    exp_q.push_back({1'b0, 8'h5A});
    reg_wr(4'd2, 8'h54);
    wait_stat(8'h80);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(tx_valid == 1'b0, "R7", "tx stalled on byte done", int'(tx_valid), 0);
    end
    rd_chk(4'd0, 8'h81, "R7", "byte done and busy");
    reg_wr(4'd7, 8'h6B);
    exp_q.push_back({1'b1, 8'h6B});
    reg_wr(4'd0, 8'h80);
    wait_stat(8'h02);
    chk(exp_q.size() == 0, "R7", "second byte released", exp_q.size(), 0);
    rd_chk(4'd0, 8'h82, "R9", "byte done and done");
    reg_wr(4'd0, 8'h82);

    // R8 byte-at-a-time I2C read with last-byte command
    xfer_read = 1'b1;
    reg_wr(4'd2, 8'h58);
    rx_send(8'h7E, f); chk(f == 1'b0, "R8", "first byte not final", int'(f), 0);
    wait_stat(8'h80);
    @(negedge clk);
    chk(rx_ready == 1'b0, "R7", "rx stalled on byte done", int'(rx_ready), 0);
    rd_chk(4'd7, 8'h7E, "R8", "first byte in holding");
    reg_wr(4'd2, 8'h38);
    rd_chk(4'd2, 8'h38, "R8", "last-byte command readback");
    reg_wr(4'd0, 8'h80);
    rx_send(8'h3C, f); chk(f == 1'b1, "R8", "last byte final", int'(f), 1);
    rd_chk(4'd0, 8'h82, "R8", "transfer ended");
    rd_chk(4'd7, 8'h3C, "R8", "last byte in holding");
    rd_chk(4'd5, 8'd2, "R8", "count unchanged");

    // R10 exclusivity is asserted in the RTL; confirm idle outputs
    chk(!tx_valid && !rx_ready, "R10", "idle streams quiet", int'({tx_valid, rx_ready}), 0);

    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule